// File: doc/BRIEF.md
# Addressable scan-bus port selector

This block is a boundary-scan slave built for a backplane where many identical cards share one TCK/TMS/TDI/TDO bus. It runs the standard 16-state TAP controller. Out of reset it is unselected. In that state it listens in an addressing mode: whatever is shifted into its instruction register and committed at Update-IR is treated as an address, not an opcode.

Three kinds of address can select the device:
- an individual address equal to its hard-wired slot number;
- the broadcast address;
- a multicast address whose group code equals the device's group register.

Once selected, the instruction register holds real opcodes. These route the scan path through one of four data registers: bypass, group, mode or boundary sample. The device stays selected until the TAP returns to Test-Logic-Reset. Outputs are a serial data bit plus a separate drive-enable that stands in for the tri-state control of the shared TDO line.

Top module: `scanbus_addr_port`

## Requirements
- R1: On Capture-IR the 8-bit instruction register loads {slot_id[5:0], 2'b01}. In Shift-IR it shifts towards TDO least significant bit first and drives TDO whether or not the device is selected.
- R2: While unselected, an address shifted in and committed at Update-IR selects the device when it lies in 0x00..0x3A and equals the zero-extended slot_id.
- R3: Address 0x3B selects the device whatever its slot_id.
- R4: Address 0x3C + g (g in 0..3) selects the device only when g equals its 2-bit group register.
- R5: Any other address, or an individual address different from slot_id, leaves the device unselected. An unselected device keeps tdo_en low throughout Shift-DR.
- R6: Entering Test-Logic-Reset, by TMS or by trst_n low, deselects the device, clears the group register to 2'b00 and sets the mode register to 8'h01.
- R7: When selected, opcode 8'hFF and every unassigned opcode select a 1-bit bypass stage that captures 0. An 8-bit DR scan of d therefore returns {d[6:0], 1'b0}.
- R8: Opcode 8'h10 selects the 2-bit group register. Capture-DR loads its value and Update-DR writes the shifted bits into it.
- R9: Opcode 8'h11 selects the 8-bit mode register. Capture-DR loads its value and Update-DR writes it.
- R10: Opcode 8'h12 selects an 8-cell sample-only register. Capture-DR loads {oe_sense, aux_sense, slot_id}, so slot_id[0] is the first bit out. Update-DR changes nothing.
- R11: tdo_en is high only in Shift-IR, or in Shift-DR while selected. tdo and tdo_en change on the falling edge of tck and hold across the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| slot_id | input | 6 | Hard-wired slot number of this card |
| aux_sense | input | 1 | Sensed seventh slot pin, sampled by the boundary cells |
| oe_sense | input | 1 | Sensed output-enable pin, sampled by the boundary cells |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Drive enable for the shared TDO line |

## Verification
The bench builds the block with its default widths: an 8-bit instruction register, a 6-bit slot, a 2-bit group and an 8-bit mode register. Multicast is enabled and the output is retimed on the falling edge. It wires slot_id to 0x15, so the captured instruction pattern is 0x55, and checks the 0x3A edge of the individual range against a non-matching slot. With a 2-bit group, all four multicast codes decode to real addresses. The bench covers a mismatched group code, the cleared-after-reset group, broadcast, and selection by individual slot, with both TMS-driven and asynchronous reset in the sequence.

// File: rtl/scanbus_pkg.sv
package scanbus_pkg;

   typedef enum logic [3:0] {
      TS_RESET, TS_IDLE,
      TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
      TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      DR_BYPASS, DR_GROUP, DR_MODE, DR_SAMPLE
   } dr_sel_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
      tap_state_e n;
      case (s)
         TS_RESET:    n = tms ? TS_RESET  : TS_IDLE;
         TS_IDLE:     n = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_DR:   n = tms ? TS_SEL_IR : TS_CAP_DR;
         TS_CAP_DR:   n = tms ? TS_EX1_DR : TS_SH_DR;
         TS_SH_DR:    n = tms ? TS_EX1_DR : TS_SH_DR;
         TS_EX1_DR:   n = tms ? TS_UPD_DR : TS_PAUSE_DR;
         TS_PAUSE_DR: n = tms ? TS_EX2_DR : TS_PAUSE_DR;
         TS_EX2_DR:   n = tms ? TS_UPD_DR : TS_SH_DR;
         TS_UPD_DR:   n = tms ? TS_SEL_DR : TS_IDLE;
         TS_SEL_IR:   n = tms ? TS_RESET  : TS_CAP_IR;
         TS_CAP_IR:   n = tms ? TS_EX1_IR : TS_SH_IR;
         TS_SH_IR:    n = tms ? TS_EX1_IR : TS_SH_IR;
         TS_EX1_IR:   n = tms ? TS_UPD_IR : TS_PAUSE_IR;
         TS_PAUSE_IR: n = tms ? TS_EX2_IR : TS_PAUSE_IR;
         TS_EX2_IR:   n = tms ? TS_UPD_IR : TS_SH_IR;
         default:     n = tms ? TS_SEL_DR : TS_IDLE;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/scanbus_tap_fsm.sv
module scanbus_tap_fsm
   import scanbus_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= TS_RESET;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/scanbus_addr_match.sv
module scanbus_addr_match #(
   parameter int              IR_W      = 8,
   parameter int              SLOT_W    = 6,
   parameter int              GRP_W     = 2,
   parameter logic [IR_W-1:0] SLOT_LAST = 8'h3A,
   parameter logic [IR_W-1:0] BCAST     = 8'h3B,
   parameter logic [IR_W-1:0] GRP_BASE  = 8'h3C,
   parameter bit              MCAST_EN  = 1'b1
) (
   input  logic [IR_W-1:0]   addr,
   input  logic [SLOT_W-1:0] slot,
   input  logic [GRP_W-1:0]  grp,
   output logic              hit
);

   localparam int TAG_W = IR_W - GRP_W;

   logic [IR_W-1:0] slot_wide;
   logic            indiv_hit;
   logic            bcast_hit;
   logic            grp_hit;

   assign slot_wide = IR_W'(slot);
   assign indiv_hit = (addr <= SLOT_LAST) && (addr == slot_wide);
   assign bcast_hit = (addr == BCAST);

   generate
      if (MCAST_EN) begin : g_mcast
         logic [TAG_W-1:0] tag_want;
         assign tag_want = GRP_BASE[IR_W-1:GRP_W];
         assign grp_hit  = (addr[IR_W-1:GRP_W] == tag_want) && (addr[GRP_W-1:0] == grp);
      end else begin : g_no_mcast
         assign grp_hit = 1'b0;
      end
   endgenerate

   assign hit = indiv_hit | bcast_hit | grp_hit;

endmodule

// File: rtl/scanbus_dr_bank.sv
module scanbus_dr_bank
   import scanbus_pkg::*;
#(
   parameter int                GRP_W    = 2,
   parameter int                MODE_W   = 8,
   parameter logic [MODE_W-1:0] MODE_RST = 8'h01,
   parameter int                BSR_W    = 8
) (
   input  logic              tck,
   input  logic              trst_n,
   input  tap_state_e        state,
   input  dr_sel_e           dr_sel,
   input  logic              selected,
   input  logic              tdi,
   input  logic [BSR_W-1:0]  bsr_in,
   output logic [GRP_W-1:0]  grp,
   output logic              dr_tdo
);

   logic              byp_q;
   logic [GRP_W-1:0]  grp_sr;
   logic [GRP_W-1:0]  grp_q;
   logic [MODE_W-1:0] mode_sr;
   logic [MODE_W-1:0] mode_q;
   logic [BSR_W-1:0]  bsr_sr;
   logic              do_cap;
   logic              do_shift;
   logic              do_upd;

   assign do_cap   = selected && (state == TS_CAP_DR);
   assign do_shift = selected && (state == TS_SH_DR);
   assign do_upd   = selected && (state == TS_UPD_DR);

   // Shift stages: capture parallel value, then move one bit towards TDO per clock.
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q   <= 1'b0;
         grp_sr  <= '0;
         mode_sr <= '0;
         bsr_sr  <= '0;
      end else if (do_cap) begin
         case (dr_sel)
            DR_GROUP:  grp_sr  <= grp_q;
            DR_MODE:   mode_sr <= mode_q;
            DR_SAMPLE: bsr_sr  <= bsr_in;
            default:   byp_q   <= 1'b0;
         endcase
      end else if (do_shift) begin
         case (dr_sel)
            DR_GROUP:  grp_sr  <= {tdi, grp_sr[GRP_W-1:1]};
            DR_MODE:   mode_sr <= {tdi, mode_sr[MODE_W-1:1]};
            DR_SAMPLE: bsr_sr  <= {tdi, bsr_sr[BSR_W-1:1]};
            default:   byp_q   <= tdi;
         endcase
      end
   end

   // Parallel holding registers, reloaded whenever the TAP sits in Test-Logic-Reset.
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         grp_q  <= '0;
         mode_q <= MODE_RST;
      end else if (state == TS_RESET) begin
         grp_q  <= '0;
         mode_q <= MODE_RST;
      end else if (do_upd) begin
         if (dr_sel == DR_GROUP) grp_q  <= grp_sr;
         if (dr_sel == DR_MODE)  mode_q <= mode_sr;
      end
   end

   always_comb begin
      case (dr_sel)
         DR_GROUP:  dr_tdo = grp_sr[0];
         DR_MODE:   dr_tdo = mode_sr[0];
         DR_SAMPLE: dr_tdo = bsr_sr[0];
         default:   dr_tdo = byp_q;
      endcase
   end

   assign grp = grp_q;

endmodule

// File: rtl/scanbus_addr_port.sv
module scanbus_addr_port
   import scanbus_pkg::*;
#(
   parameter int                IR_W        = 8,
   parameter int                SLOT_W      = 6,
   parameter int                GRP_W       = 2,
   parameter int                MODE_W      = 8,
   parameter logic [MODE_W-1:0] MODE_RST    = 8'h01,
   parameter logic [IR_W-1:0]   SLOT_LAST   = 8'h3A,
   parameter logic [IR_W-1:0]   BCAST       = 8'h3B,
   parameter logic [IR_W-1:0]   GRP_BASE    = 8'h3C,
   parameter logic [IR_W-1:0]   OP_GROUP    = 8'h10,
   parameter logic [IR_W-1:0]   OP_MODE     = 8'h11,
   parameter logic [IR_W-1:0]   OP_SAMPLE   = 8'h12,
   parameter bit                MCAST_EN    = 1'b1,
   parameter bit                TDO_ON_FALL = 1'b1
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   input  logic [SLOT_W-1:0] slot_id,
   input  logic              aux_sense,
   input  logic              oe_sense,
   output logic              tdo,
   output logic              tdo_en
);

   localparam int              BSR_W  = SLOT_W + 2;
   localparam logic [IR_W-1:0] OP_BYP = '1;

   // Elaboration-time parameter checks.
   generate
      if (IR_W < SLOT_W + 2) begin : g_bad_ir
         $error("IR_W must hold the slot value and the two fixed capture bits");
      end
      if (GRP_W < 2 || MODE_W < 2) begin : g_bad_regs
         $error("group and mode registers need at least two bits");
      end
      if (GRP_BASE[GRP_W-1:0] != '0) begin : g_bad_base
         $error("GRP_BASE must have its group-code bits clear");
      end
      if (BCAST <= SLOT_LAST) begin : g_bad_bcast
         $error("broadcast address must lie above the individual range");
      end
   endgenerate

   tap_state_e        state;
   logic [IR_W-1:0]   ir_sr;
   logic [IR_W-1:0]   ir_q;
   logic [IR_W-1:0]   ir_cap;
   logic              selected;
   logic              addr_hit;
   logic [GRP_W-1:0]  grp_q;
   dr_sel_e           dr_sel;
   logic              dr_tdo;
   logic              drive_nx;
   logic              bit_nx;

   scanbus_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state)
   );

   assign ir_cap = IR_W'({slot_id, 2'b01});

   // Instruction/address register and the selection flag.
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sr    <= '0;
         ir_q     <= OP_BYP;
         selected <= 1'b0;
      end else begin
         case (state)
            TS_RESET: begin
               ir_q     <= OP_BYP;
               selected <= 1'b0;
            end
            TS_CAP_IR: ir_sr <= ir_cap;
            TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
            TS_UPD_IR: begin
               if (selected)      ir_q     <= ir_sr;
               else if (addr_hit) selected <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   scanbus_addr_match #(
      .IR_W      (IR_W),
      .SLOT_W    (SLOT_W),
      .GRP_W     (GRP_W),
      .SLOT_LAST (SLOT_LAST),
      .BCAST     (BCAST),
      .GRP_BASE  (GRP_BASE),
      .MCAST_EN  (MCAST_EN)
   ) u_match (
      .addr (ir_sr),
      .slot (slot_id),
      .grp  (grp_q),
      .hit  (addr_hit)
   );

   always_comb begin
      if      (ir_q == OP_GROUP)  dr_sel = DR_GROUP;
      else if (ir_q == OP_MODE)   dr_sel = DR_MODE;
      else if (ir_q == OP_SAMPLE) dr_sel = DR_SAMPLE;
      else                        dr_sel = DR_BYPASS;
   end

   scanbus_dr_bank #(
      .GRP_W    (GRP_W),
      .MODE_W   (MODE_W),
      .MODE_RST (MODE_RST),
      .BSR_W    (BSR_W)
   ) u_bank (
      .tck      (tck),
      .trst_n   (trst_n),
      .state    (state),
      .dr_sel   (dr_sel),
      .selected (selected),
      .tdi      (tdi),
      .bsr_in   ({oe_sense, aux_sense, slot_id}),
      .grp      (grp_q),
      .dr_tdo   (dr_tdo)
   );

   assign drive_nx = (state == TS_SH_IR) || (selected && (state == TS_SH_DR));
   assign bit_nx   = (state == TS_SH_IR) ? ir_sr[0] : dr_tdo;

   generate
      if (TDO_ON_FALL) begin : g_fall
         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n) begin
               tdo    <= 1'b0;
               tdo_en <= 1'b0;
            end else begin
               tdo    <= bit_nx;
               tdo_en <= drive_nx;
            end
         end
      end else begin : g_direct
         assign tdo    = bit_nx;
         assign tdo_en = drive_nx;
      end
   endgenerate

endmodule

// File: rtl/scanbus_addr_port_chk.sv
module scanbus_addr_port_chk
   import scanbus_pkg::*;
#(
   parameter int GRP_W = 2
) (
   input logic             tck,
   input logic             trst_n,
   input tap_state_e       state,
   input logic             selected,
   input logic             tdo_en,
   input logic [GRP_W-1:0] grp
);

   // R11: the line is driven only in a shift state
   p_drive_in_shift_r11: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_en |-> (state == TS_SH_IR || state == TS_SH_DR));

   // R5: an unselected device drives only while an address is shifted
   p_unsel_quiet_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (!selected && tdo_en) |-> (state == TS_SH_IR));

   // R6: Test-Logic-Reset clears the group and deselects
   p_reset_clears_r6: assert property (@(posedge tck) disable iff (!trst_n)
      (state == TS_RESET) |=> (grp == '0 && !selected));

   // R2: selection happens only out of Update-IR
   p_select_at_update_r2: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(selected) |-> ($past(state) == TS_UPD_IR));

   // R8: the group register moves only at Update-DR or in reset
   p_group_write_r8: assert property (@(posedge tck) disable iff (!trst_n)
      !$stable(grp) |-> ($past(state) == TS_UPD_DR || $past(state) == TS_RESET));

endmodule

bind scanbus_addr_port scanbus_addr_port_chk #(.GRP_W(GRP_W)) u_chk (
   .tck      (tck),
   .trst_n   (trst_n),
   .state    (state),
   .selected (selected),
   .tdo_en   (tdo_en),
   .grp      (grp_q)
);

// File: tb/scanbus_addr_port_bench.sv
module scanbus_addr_port_bench;

   localparam int CLK_PERIOD = 20;

   typedef struct {
      logic  chk_en;
      logic  exp_en;
      logic  chk_bit;
      logic  exp_bit;
      string tag;
   } exp_t;

   logic       tck = 1'b0;
   logic       trst_n;
   logic       tms;
   logic       tdi;
   logic [5:0] slot_id;
   logic       aux_sense;
   logic       oe_sense;
   logic       tdo;
   logic       tdo_en;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   exp_t sb_q[$];

   scanbus_addr_port u_scanbus_addr_port (
      .tck       (tck),
      .trst_n    (trst_n),
      .tms       (tms),
      .tdi       (tdi),
      .slot_id   (slot_id),
      .aux_sense (aux_sense),
      .oe_sense  (oe_sense),
      .tdo       (tdo),
      .tdo_en    (tdo_en)
   );

   always #(CLK_PERIOD/2) tck = ~tck;

   // Monitor: pops one expected item per rising edge.
   always @(posedge tck) begin
      if (sb_q.size() > 0) begin
         exp_t it;
         logic seen;
         it   = sb_q.pop_front();
         seen = tdo;
         if (it.chk_en) begin
            checks++;
            if (tdo_en !== it.exp_en) begin
               errors++;
               $display("FAIL %s tdo_en actual=%b expected=%b", it.tag, tdo_en, it.exp_en);
            end
         end
         if (it.chk_bit) begin
            checks++;
            if (tdo !== it.exp_bit) begin
               errors++;
               $display("FAIL %s tdo actual=%b expected=%b", it.tag, tdo, it.exp_bit);
            end
            #1;
            checks++;  // R11: no change across the rising edge
            if (tdo !== seen) begin
               errors++;
               $display("FAIL R11 tdo moved at rising edge actual=%b expected=%b", tdo, seen);
            end
         end
      end
   end

   task automatic step(input logic tms_v, input logic tdi_v, input exp_t it);
      @(negedge tck);
      #1;
      tms = tms_v;
      tdi = tdi_v;
      sb_q.push_back(it);
   endtask

   task automatic idle_step(input logic tms_v);
      exp_t none;
      none = '{1'b0, 1'b0, 1'b0, 1'b0, ""};
      step(tms_v, 1'b0, none);
   endtask

   task automatic scan_ir(input logic [7:0] din, input logic [7:0] expv, input string tag);
      idle_step(1); idle_step(1); idle_step(0); idle_step(0);
      for (int i = 0; i < 8; i++) begin
         exp_t it;
         it = '{1'b1, 1'b1, 1'b1, expv[i], tag};
         step(i == 7, din[i], it);
      end
      idle_step(1); idle_step(0);
   endtask

   task automatic scan_dr(input int n, input logic [7:0] din, input logic [7:0] expv,
                          input logic en, input string tag);
      idle_step(1); idle_step(0); idle_step(0);
      for (int i = 0; i < n; i++) begin
         exp_t it;
         it = '{1'b1, en, en, expv[i], tag};
         step(i == n - 1, din[i], it);
      end
      idle_step(1); idle_step(0);
   endtask

   task automatic drain();
      while (sb_q.size() > 0) @(negedge tck);
      @(negedge tck);
   endtask

   task automatic direct_check(input logic act, input logic expv, input string msg);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", msg, act, expv);
      end
   endtask

   initial begin
      trst_n    = 1'b0;
      tms       = 1'b1;
      tdi       = 1'b0;
      slot_id   = 6'h15;
      aux_sense = 1'b0;
      oe_sense  = 1'b1;
      repeat (3) @(negedge tck);
      direct_check(tdo_en, 1'b0, "R11 reset tdo_en");
      trst_n = 1'b1;
      idle_step(0);

      // R1 capture pattern; R5 address 0x00 and 0x3A do not match slot 0x15
      scan_ir(8'h00, 8'h55, "R1");
      scan_dr(8, 8'hFF, 8'h00, 1'b0, "R5");
      scan_ir(8'h3A, 8'h55, "R5");
      scan_dr(8, 8'hFF, 8'h00, 1'b0, "R5");

      // R2 individual match, then bypass R7
      scan_ir(8'h15, 8'h55, "R2");
      scan_dr(8, 8'h6C, 8'hD8, 1'b1, "R7");

      // R9 mode register, reset value per R6
      scan_ir(8'h11, 8'h55, "R9");
      scan_dr(8, 8'hA6, 8'h01, 1'b1, "R6");
      scan_dr(8, 8'h3C, 8'hA6, 1'b1, "R9");

      // R8 group register
      scan_ir(8'h10, 8'h55, "R8");
      scan_dr(2, 8'h02, 8'h00, 1'b1, "R8");
      scan_dr(2, 8'h01, 8'h02, 1'b1, "R8");
      scan_ir(8'h11, 8'h55, "R9");
      scan_dr(8, 8'h3C, 8'h3C, 1'b1, "R9");

      // R10 sample-only cells
      scan_ir(8'h12, 8'h55, "R10");
      scan_dr(8, 8'h00, 8'h95, 1'b1, "R10");
      drain();
      aux_sense = 1'b1;
      scan_dr(8, 8'h00, 8'hD5, 1'b1, "R10");

      // R7 unassigned opcode falls back to bypass
      scan_ir(8'h37, 8'h55, "R7");
      scan_dr(8, 8'h5A, 8'hB4, 1'b1, "R7");

      // R6 reset by TMS; R4 group mismatch then match against cleared group
      repeat (5) idle_step(1);
      idle_step(0);
      scan_ir(8'h3E, 8'h55, "R4");
      scan_dr(8, 8'h00, 8'h00, 1'b0, "R4");
      scan_ir(8'h3C, 8'h55, "R4");
      scan_dr(8, 8'h81, 8'h02, 1'b1, "R4");
      scan_ir(8'h11, 8'h55, "R6");
      scan_dr(8, 8'h00, 8'h01, 1'b1, "R6");
      scan_ir(8'h10, 8'h55, "R6");
      scan_dr(2, 8'h00, 8'h00, 1'b1, "R6");

      // R6 asynchronous reset deselects; R3 broadcast
      drain();
      trst_n = 1'b0;
      #2;
      direct_check(tdo_en, 1'b0, "R6 trst tdo_en");
      @(negedge tck);
      trst_n = 1'b1;
      idle_step(0);
      scan_dr(8, 8'h00, 8'h00, 1'b0, "R6");
      scan_ir(8'h3B, 8'h55, "R3");
      scan_dr(8, 8'hC3, 8'h86, 1'b1, "R3");

      drain();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule